// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wrap

This block sits between the byte stream of a serial memory's write command and its storage array. It collects the data bytes that a host sends into a buffer the size of one page. When the command closes, it commits those bytes to the array. A write command opens with a load strobe that carries the start address. Each data byte then arrives on its own strobe. A stop strobe closes the command.

Only the low part of the address advances as bytes arrive, the part that selects a byte inside the page. A long burst therefore circles back to the start of the same page, and later bytes overwrite earlier ones. Every buffer slot carries a flag that marks it as filled. At commit time the block walks the page and issues one array write strobe for each filled slot, so every other byte of the page keeps its old contents.

A stop with data and with the protect input low starts a self-timed write cycle. The length of that cycle is a parameter counted in clock cycles, and the busy flag stays high for all of it. A stop that arrives while protect is high, or that follows no data byte, closes the command quietly. In that case there is no busy period and the array does not change.

Top module: `page_write_buffer`

## Requirements
- R1: While reset is held and in the cycle after it is released, busy is low, arr_we is low and ptr_addr is zero.
- R2: A cmd_load accepted while not busy sets ptr_addr to cmd_addr in the next cycle and empties every buffer slot of the page.
- R3: A byte_vld accepted during an open command stores byte_data at the slot given by the low log2(PAGE_BYTES) bits of ptr_addr. It then increments those bits by one, modulo PAGE_BYTES, and leaves the upper page bits unchanged.
- R4: When more than PAGE_BYTES bytes arrive in one command, later bytes replace earlier ones in the same slot, and each slot yields at most one array write strobe.
- R5: The commit writes only the locations that received a byte during the command (page bits of ptr_addr, slot index), and every other array location keeps its value.
- R6: A stop accepted with at least one buffered byte and wr_protect low raises busy in the next cycle for exactly WR_CYCLES cycles. Every arr_we pulse of the commit falls inside that window.
- R7: If wr_protect is high in the cycle of the stop, no arr_we pulse is issued and busy stays low.
- R8: Changing wr_protect while busy is high has no effect on the running commit.
- R9: A stop that follows no data byte in the open command raises neither busy nor arr_we.
- R10: While busy is high, cmd_load, byte_vld and stop are ignored. Outside an open command, byte_vld is ignored. Neither changes ptr_addr or the array.
- R11: After a command, ptr_addr holds the page bits of the start address, with a slot index equal to the start slot plus the number of bytes received, modulo PAGE_BYTES. After a single byte, this is the next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Opens a write command at cmd_addr |
| cmd_addr | input | ADDR_W | Start address of the command |
| byte_vld | input | 1 | One data byte is present |
| byte_data | input | DATA_W | Data byte |
| stop | input | 1 | Closes the command |
| wr_protect | input | 1 | High blocks the commit, sampled with stop |
| busy | output | 1 | Self-timed write cycle in progress |
| ptr_addr | output | ADDR_W | Current internal address pointer |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The bench goes after bursts that cross the page end, bursts longer than one page, and writes of a single byte at the last slot of a page. A design that carried into the page bits would write into the next page. A design without per-slot flags would clear or rewrite the untouched bytes of the page, which the full array comparison catches. It also drives a protected stop, an empty stop, a protect toggle during busy, and a command, bytes and a stop issued during busy. A faulty design would start a stray write cycle, abort or shorten a running one, or move the pointer.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FILL   = 2'd1,
    PH_COMMIT = 2'd2,
    PH_SETTLE = 2'd3
  } pwb_phase_e;
endpackage

// File: rtl/pwb_addr.sv
module pwb_addr #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  // Only the slot bits move on a step; the page bits hold.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_addr;
    end else if (step) begin
      addr[OFF_W-1:0] <= addr[OFF_W-1:0] + OFF_W'(1);
    end
  end
endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit,
  output logic [OFF_W-1:0]  rd_off_q
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  filled;

  // Data storage: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_off] <= wr_data;
    rd_data <= mem[rd_off];
  end

  // Per-slot fill flags, cleared in one cycle at command open.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      filled <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && wr_off == OFF_W'(i)) filled[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit   <= 1'b0;
      rd_off_q <= '0;
    end else begin
      rd_hit   <= rd_en & filled[rd_off];
      rd_off_q <= rd_off;
    end
  end
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int OFF_W      = 4,
  parameter int WR_CYCLES  = 40,
  localparam int CNT_W     = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_load,
  input  logic             byte_vld,
  input  logic             stop,
  input  logic             wr_protect,
  output logic             load_ok,
  output logic             byte_ok,
  output logic             busy,
  output logic             pending,
  output logic             scan_en,
  output logic [OFF_W-1:0] scan_off
);
  pwb_phase_e       phase;
  logic             has_data;
  logic [CNT_W-1:0] cnt;
  logic             stop_ok;

  assign busy    = (phase == PH_COMMIT) || (phase == PH_SETTLE);
  assign stop_ok = stop & ~busy;
  assign load_ok = cmd_load & ~busy & ~stop;
  assign byte_ok = byte_vld & (phase == PH_FILL) & ~stop & ~cmd_load;
  assign pending = (phase == PH_FILL) & has_data;
  assign scan_en = (phase == PH_COMMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      has_data <= 1'b0;
      cnt      <= '0;
      scan_off <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (load_ok) begin
            phase    <= PH_FILL;
            has_data <= 1'b0;
          end
        end
        PH_FILL: begin
          if (stop_ok) begin
            has_data <= 1'b0;
            if (has_data && !wr_protect) begin
              phase    <= PH_COMMIT;
              cnt      <= CNT_W'(WR_CYCLES - 1);
              scan_off <= '0;
            end else begin
              phase <= PH_IDLE;
            end
          end else if (load_ok) begin
            has_data <= 1'b0;
          end else if (byte_ok) begin
            has_data <= 1'b1;
          end
        end
        PH_COMMIT: begin
          cnt      <= cnt - CNT_W'(1);
          scan_off <= scan_off + OFF_W'(1);
          if (scan_off == OFF_W'(PAGE_BYTES - 1)) phase <= PH_SETTLE;
        end
        default: begin
          if (cnt == '0) phase <= PH_IDLE;
          else cnt <= cnt - CNT_W'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 40,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_load,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop,
  input  logic              wr_protect,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  logic              load_ok, byte_ok, pending, scan_en;
  logic [OFF_W-1:0]  scan_off, rd_off_q;
  logic [DATA_W-1:0] rd_data;
  logic              rd_hit;

  pwb_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_load(cmd_load), .byte_vld(byte_vld),
    .stop(stop), .wr_protect(wr_protect), .load_ok(load_ok),
    .byte_ok(byte_ok), .busy(busy), .pending(pending),
    .scan_en(scan_en), .scan_off(scan_off)
  );

  pwb_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk(clk), .rst(rst), .load(load_ok), .load_addr(cmd_addr),
    .step(byte_ok), .addr(ptr_addr)
  );

  pwb_store #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES), .OFF_W(OFF_W)) u_store (
    .clk(clk), .rst(rst), .clr(load_ok), .wr_en(byte_ok),
    .wr_off(ptr_addr[OFF_W-1:0]), .wr_data(byte_data),
    .rd_en(scan_en), .rd_off(scan_off), .rd_data(rd_data),
    .rd_hit(rd_hit), .rd_off_q(rd_off_q)
  );

  // Registered array strobe; page bits cannot move while busy.
  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      arr_we    <= rd_hit;
      arr_addr  <= {ptr_addr[ADDR_W-1:OFF_W], rd_off_q};
      arr_wdata <= rd_data;
    end
  end
endmodule

// File: rtl/page_write_buffer_chk.sv
module page_write_buffer_chk #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 40,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_load,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              byte_vld,
  input logic              stop,
  input logic              wr_protect,
  input logic              busy,
  input logic              pending,
  input logic [ADDR_W-1:0] ptr_addr,
  input logic              arr_we
);
  logic [31:0] run;

  initial begin
    assert (WR_CYCLES >= PAGE_BYTES + 3)
      else $error("WR_CYCLES too short for a page scan");
  end

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (busy) run <= run + 32'd1;
    else run <= '0;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> !busy && !arr_we && ptr_addr == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_load && !busy && !stop |=> ptr_addr == $past(cmd_addr));

  p_page_hold_r3: assert property (@(posedge clk) disable iff (rst)
    byte_vld && !cmd_load && !stop |=>
      ptr_addr[ADDR_W-1:OFF_W] == $past(ptr_addr[ADDR_W-1:OFF_W]));

  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  p_start_r6: assert property (@(posedge clk) disable iff (rst)
    stop && !busy && pending && !wr_protect |=> busy);

  p_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run == 32'(WR_CYCLES));

  p_protect_r7: assert property (@(posedge clk) disable iff (rst)
    stop && !busy && wr_protect |=> !busy);

  p_empty_r9: assert property (@(posedge clk) disable iff (rst)
    stop && !busy && !pending |=> !busy);

  p_hold_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ptr_addr));
endmodule

bind page_write_buffer page_write_buffer_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
  .byte_vld(byte_vld), .stop(stop), .wr_protect(wr_protect),
  .busy(busy), .pending(pending), .ptr_addr(ptr_addr), .arr_we(arr_we)
);

// File: tb/test_page_write_buffer.sv
module test_page_write_buffer;
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int PG   = 16;
  localparam int WRC  = 40;
  localparam int NVEC = 8;
  // {start addr, byte count, flags(bit0 protect), data seed}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h10_01_00_A0,  // single byte
    32'h23_05_00_30,  // short burst inside page
    32'h3C_06_00_50,  // crosses page end, wraps
    32'h45_14_00_70,  // 20 bytes, overwrite
    32'h23_03_01_90,  // protected
    32'h50_00_00_00,  // no data
    32'h2F_01_00_B0,  // single byte at last slot
    32'hF0_10_00_C0   // exactly one page
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_load = 1'b0, byte_vld = 1'b0, stop = 1'b0, wr_protect = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] byte_data = '0;
  logic busy, arr_we;
  logic [AW-1:0] ptr_addr, arr_addr;
  logic [DW-1:0] arr_wdata;

  int checks = 0, fails = 0, strobes = 0, run_cur = 0, last_run = 0;
  bit done = 1'b0;
  logic [DW-1:0] arr_mem [256];
  logic [DW-1:0] exp_mem [256];

  always #10 clk = ~clk;

  page_write_buffer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PG), .WR_CYCLES(WRC))
    i_page_write_buffer (
      .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
      .byte_vld(byte_vld), .byte_data(byte_data), .stop(stop),
      .wr_protect(wr_protect), .busy(busy), .ptr_addr(ptr_addr),
      .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  // Array model fed only by the strobes, plus busy run measurement.
  always @(negedge clk) begin
    if (arr_we) begin
      arr_mem[arr_addr] = arr_wdata;
      strobes++;
    end
    if (busy) run_cur++;
    else if (run_cur != 0) begin
      last_run = run_cur;
      run_cur = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_array(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (arr_mem[i] !== exp_mem[i]) bad++;
    chk(tag, bad, 0);
  endtask

  // mode 0: plain, 1: toggle protect during busy (R8), 2: traffic during busy (R10)
  task automatic run_cmd(input logic [7:0] a, input int n, input bit wp,
                         input logic [7:0] seed, input int mode);
    int s0 = strobes;
    bit go = (n > 0) && !wp;
    int nw = (n > PG) ? PG : n;
    logic [7:0] ep = {a[7:4], 4'(a[3:0] + n[3:0])};
    @(negedge clk); cmd_load = 1'b1; cmd_addr = a; last_run = 0;
    @(negedge clk); cmd_load = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_vld = 1'b1; byte_data = 8'(seed + k);
      @(negedge clk);
    end
    byte_vld = 1'b0; wr_protect = wp; stop = 1'b1;
    @(negedge clk); stop = 1'b0; wr_protect = 1'b0;
    if (go) for (int k = 0; k < n; k++) exp_mem[{a[7:4], 4'(a[3:0] + k)}] = 8'(seed + k);
    if (mode == 1) begin
      wr_protect = 1'b1; repeat (6) @(negedge clk); wr_protect = 1'b0;
    end else if (mode == 2) begin
      cmd_load = 1'b1; cmd_addr = 8'h80; @(negedge clk); cmd_load = 1'b0;
      for (int k = 0; k < 3; k++) begin
        byte_vld = 1'b1; byte_data = 8'hEE; @(negedge clk);
      end
      byte_vld = 1'b0; stop = 1'b1; @(negedge clk); stop = 1'b0;
    end
    repeat (WRC + 6) @(negedge clk);
    chk("R6/R7/R9 busy length", last_run, go ? WRC : 0);
    chk("R4/R7 strobe count", strobes - s0, go ? nw : 0);
    chk("R11 pointer after command", ptr_addr, ep);
    cmp_array("R3/R4/R5 array contents");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin arr_mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 arr_we in reset", arr_we, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pointer after reset", ptr_addr, 0);
    // R10: stray bytes and stop with no open command
    byte_vld = 1'b1; byte_data = 8'h55; repeat (3) @(negedge clk);
    byte_vld = 1'b0; stop = 1'b1; @(negedge clk); stop = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 stray bytes leave pointer", ptr_addr, 0);
    chk("R10 stray stop no busy", busy | arr_we, 0);
    // R2..R7, R9, R11 from the table
    for (int v = 0; v < NVEC; v++)
      run_cmd(VEC[v][31:24], int'(VEC[v][23:16]), VEC[v][8], VEC[v][7:0], 0);
    // R8: protect toggled while busy
    run_cmd(8'h31, 4, 1'b0, 8'hD0, 1);
    // R10: command, bytes and stop during busy are ignored
    run_cmd(8'h60, 2, 1'b0, 8'h11, 2);
    // R2: fresh command after overflow writes only its own slots
    run_cmd(8'h44, 2, 1'b0, 8'h01, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule